// File: doc/BRIEF.md
# Shared-Datapath Quadratic Evaluator

This block evaluates y = A·x² + B·x + C for signed 16-bit operands A, B, C and x. It does not build a separate multiplier for each term. It uses the nested form y = (A·x + B)·x + C and runs both multiply-add steps through a single multiplier and a single adder. Two 2:1 operand selectors feed that pair:

- In the first round, the multiplier takes A and the adder takes B. The partial value A·x + B is written into an intermediate register.
- In the second round, the multiplier takes the intermediate register and the adder takes C. The result is written to the output register.

A pulse on `start` while the block is idle captures all four operands. A small sequencer then runs the two rounds, one clock each. It raises `done` for one cycle when `y` carries the new result. `y` keeps that value until the next result replaces it. The partial value and the result are 48 bits wide, which covers every operand combination without wrap-around.

Top module: `quad_horner_eval`

## Requirements
- R1: While `rst_n` is low, and after it is released with no start, `done` is 0 and `y` is 0.
- R2: The result in `y` equals A·x² + B·x + C exactly. It is computed from the operands captured at acceptance and is read as a 48-bit two's-complement value.
- R3: If `start` is sampled high by a clock edge while the block is idle, `done` is high for exactly one cycle. That cycle follows the second clock edge after the accepting edge, and `y` holds the new result during it.
- R4: Outside the cycle in which a new result is written, `y` keeps its previous value.
- R5: A, B, C and x are captured at the accepting edge. Changes on these inputs after that edge do not affect the result.
- R6: A `start` seen during the two clock edges that follow acceptance is ignored. It does not begin a new computation and does not alter the one in progress.
- R7: A `start` sampled by the edge that ends the `done` cycle is accepted. With `start` held high, a new result therefore appears every three cycles.
- R8: Full-scale operands (−32768 and 32767, in any mix) produce the exact result with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new evaluation; effective only when idle |
| coef_a | input | 16 | Signed coefficient of x² |
| coef_b | input | 16 | Signed coefficient of x |
| coef_c | input | 16 | Signed constant term |
| x_in | input | 16 | Signed variable x |
| y | output | 48 | Signed result A·x² + B·x + C |
| done | output | 1 | One-cycle pulse marking a new result on `y` |

## Verification
Two events can fall in the same cycle: a completion (`done` high with a fresh `y`) and the acceptance of the next request.

The bench provokes this by holding `start` high for many cycles, so that every completion cycle also carries a new request. It also changes the operands on every cycle while a job is running.

A behavioural model counts the busy phases and computes each expected result with 64-bit integers. On every cycle the bench compares `done` and `y` against the model. The check confirms that the overlapping request is taken and that the result just published is not disturbed by the new job.

// File: rtl/qhe_pkg.sv
package qhe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RND1 = 2'd1,
    ST_RND2 = 2'd2
  } qhe_state_t;
endpackage

// File: rtl/qhe_seq.sv
module qhe_seq
  import qhe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic rnd2_sel,
  output logic load_mid,
  output logic load_res,
  output logic done
);
  qhe_state_t state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_RND1;
      ST_RND1: state_d = ST_RND2;
      ST_RND2: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign accept   = (state_q == ST_IDLE) && start;
  assign rnd2_sel = (state_q == ST_RND2);
  assign load_mid = (state_q == ST_RND1);
  assign load_res = (state_q == ST_RND2);
  assign done_d   = load_res;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // R3: completion marker lasts one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: first round is always followed by the second
  p_round_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RND1) |=> (state_q == ST_RND2));
  // R6: a running job never restarts the first round
  p_busy_ignores_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_RND1));
  // R3: the result write leads to the completion marker
  p_write_then_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_res |=> done);
endmodule

// File: rtl/qhe_operands.sv
module qhe_operands #(
  parameter int IN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [IN_W-1:0] a_in,
  input  logic [IN_W-1:0] b_in,
  input  logic [IN_W-1:0] c_in,
  input  logic [IN_W-1:0] x_in,
  output logic [IN_W-1:0] a_q,
  output logic [IN_W-1:0] b_q,
  output logic [IN_W-1:0] c_q,
  output logic [IN_W-1:0] x_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
      x_q <= '0;
    end else if (accept) begin
      a_q <= a_in;
      b_q <= b_in;
      c_q <= c_in;
      x_q <= x_in;
    end
  end

  // R5: captured operands move only when a request is accepted
  p_ops_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(a_q) && $stable(b_q) && $stable(c_q) && $stable(x_q)));
endmodule

// File: rtl/qhe_datapath.sv
module qhe_datapath #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  a_q,
  input  logic [IN_W-1:0]  b_q,
  input  logic [IN_W-1:0]  c_q,
  input  logic [IN_W-1:0]  x_q,
  input  logic             rnd2_sel,
  input  logic             load_mid,
  input  logic             load_res,
  output logic [ACC_W-1:0] y
);
  localparam int EXT_W = ACC_W - IN_W;

  logic signed [ACC_W-1:0] a_ext, b_ext, c_ext, x_ext;
  logic signed [ACC_W-1:0] mid_q, res_q;
  logic signed [ACC_W-1:0] mul_lhs, add_rhs, product, total;

  assign a_ext = {{EXT_W{a_q[IN_W-1]}}, a_q};
  assign b_ext = {{EXT_W{b_q[IN_W-1]}}, b_q};
  assign c_ext = {{EXT_W{c_q[IN_W-1]}}, c_q};
  assign x_ext = {{EXT_W{x_q[IN_W-1]}}, x_q};

  // operand selectors: round 1 uses A/B, round 2 uses partial/C
  always_comb begin
    mul_lhs = rnd2_sel ? mid_q : a_ext;
    add_rhs = rnd2_sel ? c_ext : b_ext;
  end

  // the single shared multiplier and adder
  assign product = mul_lhs * x_ext;
  assign total   = product + add_rhs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mid_q <= '0;
    else if (load_mid) mid_q <= total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else if (load_res) res_q <= total;
  end

  assign y = res_q;

  // R4: result register holds between writes
  p_y_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_res |=> $stable(res_q));
  // R2: the two rounds never overlap
  p_round_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_mid && load_res));
endmodule

// File: rtl/quad_horner_eval.sv
module quad_horner_eval #(
  parameter int IN_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [IN_W-1:0]     coef_a,
  input  logic [IN_W-1:0]     coef_b,
  input  logic [IN_W-1:0]     coef_c,
  input  logic [IN_W-1:0]     x_in,
  output logic [3*IN_W-1:0]   y,
  output logic                done
);
  localparam int ACC_W = 3 * IN_W;

  logic            accept, rnd2_sel, load_mid, load_res;
  logic [IN_W-1:0] a_q, b_q, c_q, x_q;

  qhe_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .rnd2_sel(rnd2_sel), .load_mid(load_mid), .load_res(load_res), .done(done)
  );

  qhe_operands #(.IN_W(IN_W)) u_ops (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .a_in(coef_a), .b_in(coef_b), .c_in(coef_c), .x_in(x_in),
    .a_q(a_q), .b_q(b_q), .c_q(c_q), .x_q(x_q)
  );

  qhe_datapath #(.IN_W(IN_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .a_q(a_q), .b_q(b_q), .c_q(c_q), .x_q(x_q),
    .rnd2_sel(rnd2_sel), .load_mid(load_mid), .load_res(load_res), .y(y)
  );
endmodule

// File: tb/test_quad_horner_eval.sv
module test_quad_horner_eval;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic signed [15:0] ca = '0, cb = '0, cc = '0, cx = '0;
  logic [47:0]        y;
  logic               done;

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  string tag = "R1";

  int     phase = 0;
  longint job = 0;
  longint exp_y = 0;
  logic   exp_done = 1'b0;

  always #4 clk = ~clk;

  quad_horner_eval i_quad_horner_eval (
    .clk(clk), .rst_n(rst_n), .start(start),
    .coef_a(ca), .coef_b(cb), .coef_c(cc), .x_in(cx),
    .y(y), .done(done)
  );

  // behavioural reference: idle / two busy phases
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      phase = 0; exp_done = 1'b0; exp_y = 0;
    end else begin
      exp_done = 1'b0;
      case (phase)
        0: if (start) begin
             job = longint'(ca) * longint'(cx) * longint'(cx)
                 + longint'(cb) * longint'(cx) + longint'(cc);
             phase = 1;
           end
        1: phase = 2;
        default: begin exp_y = job; exp_done = 1'b1; phase = 0; end
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    logic signed [47:0] ys;
    ys = y;
    checks++;
    if (done !== exp_done) begin
      fails++;
      $display("FAIL %s/R3 done: actual %0b expected %0b", tag, done, exp_done);
    end
    checks++;
    if (longint'(ys) !== exp_y) begin
      fails++;
      $display("FAIL %s y (R2/R4): actual %0d expected %0d", tag, ys, exp_y);
    end
  end

  task automatic drive(input logic s, input int a, input int b, input int c, input int x);
    @(negedge clk);
    start = s; ca = 16'(a); cb = 16'(b); cc = 16'(c); cx = 16'(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 0, 0);
  endtask

  initial begin
    int seed;
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R2, R3, R4: isolated jobs with gaps
    tag = "R2";
    drive(1'b1, 3, -5, 7, 2);   idle(6);
    drive(1'b1, -1, 0, 100, -9); idle(4);
    drive(1'b1, 0, 0, -42, 1234); idle(5);

    // R5: operands change on every busy cycle
    tag = "R5";
    drive(1'b1, 11, 22, 33, -4);
    drive(1'b0, 999, -999, 5, 77);
    drive(1'b0, -123, 456, -789, 321);
    idle(4);

    // R6: start raised while busy, with other operands
    tag = "R6";
    drive(1'b1, 2, 3, 4, 5);
    drive(1'b1, 100, 100, 100, 100);
    drive(1'b1, -7, -7, -7, -7);
    idle(5);

    // R7: start held high, done and new acceptance overlap
    tag = "R7";
    seed = 17;
    for (int i = 0; i < 24; i++) begin
      seed = seed * 1103515245 + 12345;
      drive(1'b1, seed >>> 3, seed >>> 7, seed >>> 11, seed >>> 15);
    end
    idle(5);

    // R8: full-scale operands
    tag = "R8";
    drive(1'b1, -32768, -32768, -32768, -32768); idle(3);
    drive(1'b1, 32767, 32767, 32767, 32767);     idle(3);
    drive(1'b1, -32768, 32767, -32768, -32768);  idle(3);
    drive(1'b1, 32767, -32768, 32767, -32768);   idle(4);

    // R4: long hold of last result
    tag = "R4";
    idle(10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule